// File: doc/BRIEF.md
# Receive-Only Request Counter with Word Packing

This block drives the receive-only side of a serial-peripheral master. Software loads a byte count into a 16-bit request input. From then on the block enables the serial clock and accepts the bytes that the external shifter delivers. Each accepted byte lowers a live outstanding-byte counter. Accepted bytes are packed into 32-bit words, which are handed to a receive FIFO together with the number of valid bytes in each word.

A word is closed in either of two cases: its fourth byte arrives, or the outstanding count reaches zero. A closed word waits in a one-word holding register until the FIFO has space. While a closed word cannot be written, the serial clock is held off. The stream therefore pauses between bytes and no byte is lost. Each word handed to the FIFO raises a one-cycle receive interrupt, so the FIFO can be drained.

Top module: `rx_req_packer`

## Requirements
- R1: After reset, todoCount is 0, and sckEn, pushValid and rxIrq are all low.
- R2: A request write with a nonzero count while todoCount is 0 loads todoCount with that count, visible the cycle after the write. sckEn is high from that cycle on, unless a word is held against a full FIFO.
- R3: A request write with a count of 0 is ignored. A request write while todoCount is nonzero is ignored. In both cases todoCount is unaffected.
- R4: A byte is accepted only when byteValid and sckEn are both high. Each accepted byte lowers todoCount by one in the following cycle. sckEn is low whenever todoCount is 0. A byteValid pulse while sckEn is low changes nothing.
- R5: A full word carries four bytes and pushBytes = 4. The earliest received byte is in pushData[31:24] and the latest is in pushData[7:0].
- R6: When todoCount reaches zero with n (1 to 3) bytes collected, that partial word is pushed with pushBytes = n. Its bytes are right-aligned: the latest byte is in [7:0] and the earliest is in the highest valid byte. Bits above the valid bytes are zero.
- R7: pushValid is never high while fifoFull is high. A closed word is held until fifoFull falls. While a word is held and fifoFull is high, sckEn is low. No accepted byte is dropped.
- R8: rxIrq is a one-cycle pulse, high exactly in the cycle after each cycle in which pushValid is high.
- R9: A word closed by an accepted byte appears on pushValid in the next cycle, provided fifoFull is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqWrEn | input | 1 | Software write strobe for the request count |
| reqCount | input | 16 | Number of bytes requested |
| byteValid | input | 1 | Shifter reports a completed received byte |
| byteData | input | 8 | The received byte |
| fifoFull | input | 1 | Receive FIFO cannot take a word this cycle |
| sckEn | output | 1 | Serial clock enable |
| todoCount | output | 16 | Bytes still outstanding from the current request |
| pushValid | output | 1 | Word written to the FIFO this cycle |
| pushData | output | 32 | Packed word |
| pushBytes | output | 3 | Valid bytes in pushData (1 to 4) |
| rxIrq | output | 1 | Receive interrupt pulse |

## Verification
The timing of each result is fixed:
- todoCount changes one cycle after the accepted write or byte.
- A closed word shows on pushValid the following cycle, or later if fifoFull holds it back.
- rxIrq follows each push by exactly one cycle.
- sckEn and pushValid respond to fifoFull in the same cycle.

The bench keeps a behavioural model that advances on each rising edge from the inputs it applied. It compares every output against that model at the falling edge, so each result is sampled in the cycle it is due.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

  // Strobes issued by the control path to the packing datapath
  typedef struct packed {
    logic loadTodo;    // accept a new request count
    logic acceptByte;  // shifter byte taken this cycle
    logic closeWord;   // accepted byte completes a word
    logic pushWord;    // held word written to the FIFO this cycle
  } rxpkStrobes_t;

endpackage

// File: rtl/rxpk_ctrl.sv
module rxpk_ctrl
  import rxpk_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int WORD_BYTES = 4,
  parameter int BV_W       = $clog2(WORD_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqWrEn,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             byteValid,
  input  logic             fifoFull,
  input  logic             pendValid,
  input  logic [BV_W-1:0]  accCnt,
  output rxpkStrobes_t     strobes,
  output logic [CNT_W-1:0] todoCount,
  output logic             sckEn,
  output logic             rxIrq
);

  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(1);
  localparam logic [BV_W-1:0]  LAST_SLOT = BV_W'(WORD_BYTES - 1);

  logic [CNT_W-1:0] todoQ;
  logic             busy;
  logic             blocked;
  logic             irqQ;

  assign busy    = (todoQ != '0);
  assign blocked = pendValid & fifoFull;
  assign sckEn   = busy & ~blocked;

  always_comb begin
    strobes            = '0;
    strobes.loadTodo   = reqWrEn & (reqCount != '0) & ~busy;
    strobes.acceptByte = byteValid & sckEn;
    strobes.closeWord  = strobes.acceptByte & ((accCnt == LAST_SLOT) | (todoQ == LAST_BYTE));
    strobes.pushWord   = pendValid & ~fifoFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      todoQ <= '0;
      irqQ  <= 1'b0;
    end else begin
      if (strobes.loadTodo)
        todoQ <= reqCount;
      else if (strobes.acceptByte)
        todoQ <= todoQ - LAST_BYTE;
      irqQ <= strobes.pushWord;
    end
  end

  assign todoCount = todoQ;
  assign rxIrq     = irqQ;

endmodule

// File: rtl/rxpk_dp.sv
module rxpk_dp
  import rxpk_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4,
  parameter int BV_W       = $clog2(WORD_BYTES + 1),
  parameter int WORD_W     = BYTE_W * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxpkStrobes_t      strobes,
  input  logic [BYTE_W-1:0] byteData,
  output logic              pendValid,
  output logic [BV_W-1:0]   accCnt,
  output logic [WORD_W-1:0] pushData,
  output logic [BV_W-1:0]   pushBytes
);

  localparam logic [BV_W-1:0] ONE_BYTE = BV_W'(1);

  logic [WORD_W-1:0] accQ;
  logic [BV_W-1:0]   cntQ;
  logic [WORD_W-1:0] nextAcc;
  logic [WORD_W-1:0] pendDataQ;
  logic [BV_W-1:0]   pendBytesQ;
  logic              pendQ;

  // Shift left so the earliest byte drifts toward the top of the word
  assign nextAcc = {accQ[WORD_W-BYTE_W-1:0], byteData};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      cntQ <= '0;
    end else if (strobes.acceptByte) begin
      if (strobes.closeWord) begin
        accQ <= '0;
        cntQ <= '0;
      end else begin
        accQ <= nextAcc;
        cntQ <= cntQ + ONE_BYTE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ      <= 1'b0;
      pendDataQ  <= '0;
      pendBytesQ <= '0;
    end else if (strobes.closeWord) begin
      pendQ      <= 1'b1;
      pendDataQ  <= nextAcc;
      pendBytesQ <= cntQ + ONE_BYTE;
    end else if (strobes.pushWord) begin
      pendQ <= 1'b0;
    end
  end

  assign pendValid = pendQ;
  assign accCnt    = cntQ;
  assign pushData  = pendDataQ;
  assign pushBytes = pendBytesQ;

endmodule

// File: rtl/rx_req_packer.sv
module rx_req_packer
  import rxpk_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int BYTE_W     = 8,
  parameter int WORD_BYTES = 4,
  parameter int BV_W       = $clog2(WORD_BYTES + 1),
  parameter int WORD_W     = BYTE_W * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWrEn,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              fifoFull,
  output logic              sckEn,
  output logic [CNT_W-1:0]  todoCount,
  output logic              pushValid,
  output logic [WORD_W-1:0] pushData,
  output logic [BV_W-1:0]   pushBytes,
  output logic              rxIrq
);

  rxpkStrobes_t    strobes;
  logic            pendValid;
  logic [BV_W-1:0] accCnt;

  rxpk_ctrl #(
    .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES), .BV_W(BV_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqWrEn(reqWrEn), .reqCount(reqCount),
    .byteValid(byteValid), .fifoFull(fifoFull), .pendValid(pendValid),
    .accCnt(accCnt), .strobes(strobes), .todoCount(todoCount),
    .sckEn(sckEn), .rxIrq(rxIrq)
  );

  rxpk_dp #(
    .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES), .BV_W(BV_W), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteData(byteData),
    .pendValid(pendValid), .accCnt(accCnt), .pushData(pushData),
    .pushBytes(pushBytes)
  );

  assign pushValid = strobes.pushWord;

endmodule

// File: rtl/rx_req_packer_chk.sv
module rx_req_packer_chk #(
  parameter int CNT_W      = 16,
  parameter int WORD_BYTES = 4,
  parameter int BV_W       = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqWrEn,
  input logic [CNT_W-1:0] reqCount,
  input logic             byteValid,
  input logic             fifoFull,
  input logic             sckEn,
  input logic [CNT_W-1:0] todoCount,
  input logic             pushValid,
  input logic [BV_W-1:0]  pushBytes,
  input logic             rxIrq
);

  // R2
  req_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqWrEn && reqCount != '0 && todoCount == '0) |=> (todoCount == $past(reqCount)));

  // R3
  req_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqWrEn && todoCount != '0 && !(byteValid && sckEn)) |=> $stable(todoCount));

  // R4
  byte_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && sckEn) |=> (todoCount == $past(todoCount) - CNT_W'(1)));

  // R4
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (todoCount == '0) |-> !sckEn);

  // R4
  no_byte_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sckEn && !reqWrEn) |=> $stable(todoCount));

  // R7
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !pushValid);

  // R5
  bytes_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |-> (pushBytes != '0 && pushBytes <= BV_W'(WORD_BYTES)));

  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |=> rxIrq);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pushValid |=> !rxIrq);

endmodule

bind rx_req_packer rx_req_packer_chk #(
  .CNT_W(CNT_W), .WORD_BYTES(WORD_BYTES), .BV_W(BV_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqWrEn(reqWrEn), .reqCount(reqCount),
  .byteValid(byteValid), .fifoFull(fifoFull), .sckEn(sckEn),
  .todoCount(todoCount), .pushValid(pushValid), .pushBytes(pushBytes),
  .rxIrq(rxIrq)
);

// File: tb/rx_req_packer_tb.sv
`timescale 1ns/1ps
module rx_req_packer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqWrEn = 1'b0;
  logic [15:0] reqCount = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        fifoFull = 1'b0;
  logic        sckEn;
  logic [15:0] todoCount;
  logic        pushValid;
  logic [31:0] pushData;
  logic [2:0]  pushBytes;
  logic        rxIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int cycles = 0;
  int fullSeen = 0;
  int partialSeen = 0;
  int holdSeen = 0;

  // behavioural reference state
  int         mTodo = 0;
  logic [7:0] mQ[$];
  bit         mPend = 0;
  logic [31:0] mPendData = '0;
  int         mPendBytes = 0;
  bit         mIrq = 0;

  always #2.5 clk = ~clk;

  rx_req_packer u_dut (
    .clk(clk), .rstN(rstN), .reqWrEn(reqWrEn), .reqCount(reqCount),
    .byteValid(byteValid), .byteData(byteData), .fifoFull(fifoFull),
    .sckEn(sckEn), .todoCount(todoCount), .pushValid(pushValid),
    .pushData(pushData), .pushBytes(pushBytes), .rxIrq(rxIrq)
  );

  function automatic bit expSck();
    return (mTodo != 0) && !(mPend && fifoFull);
  endfunction

  function automatic bit expPush();
    return mPend && !fifoFull;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTodo = 0; mQ.delete(); mPend = 0; mPendData = '0; mPendBytes = 0; mIrq = 0;
    end else begin
      bit push;
      bit acc;
      bit closed;
      push = expPush();
      acc = byteValid && expSck();
      closed = 0;
      mIrq = push;
      if (reqWrEn && reqCount != 0 && mTodo == 0) mTodo = int'(reqCount);
      if (acc) begin
        mQ.push_back(byteData);
        mTodo = mTodo - 1;
        if (mQ.size() == 4 || mTodo == 0) begin
          mPendData = '0;
          foreach (mQ[i]) mPendData = {mPendData[23:0], mQ[i]};
          mPendBytes = mQ.size();
          mQ.delete();
          closed = 1;
        end
      end
      if (closed) mPend = 1;
      else if (push) mPend = 0;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    check("R2 R3 R4 todoCount", todoCount, mTodo);
    check("R4 R7 sckEn", sckEn, expSck());
    check("R7 R9 pushValid", pushValid, expPush());
    check("R8 rxIrq", rxIrq, mIrq);
    if (mPend && fifoFull) holdSeen++;
    if (expPush()) begin
      check("R5 R6 pushData", pushData, mPendData);
      check("R5 R6 pushBytes", pushBytes, mPendBytes);
      if (mPendBytes == 4) fullSeen++;
      else partialSeen++;
    end
  endtask

  // one cycle: compare at the falling edge, then drive the next inputs
  task automatic step(input bit wr, input int cnt, input bit bv, input bit full);
    @(negedge clk);
    compareAll();
    reqWrEn = wr;
    reqCount = 16'(cnt);
    byteValid = bv;
    byteData = byteData + 8'h2d;
    fifoFull = full;
  endtask

  task automatic runReq(input int cnt, input int gap, input int fullMode, input int midWrite);
    step(1'b1, cnt, 1'b0, 1'b0);
    for (int i = 1; i < 600; i++) begin
      bit full;
      full = (fullMode == 1) ? ((i % 9) < 4) : ((fullMode == 2) ? ((i % 5) < 3) : 1'b0);
      step(i == midWrite, 33, (i % gap) == 0, full);
      if (mTodo == 0 && !mPend && i > 2) break;
    end
    for (int k = 0; k < 3; k++) step(1'b0, 0, 1'b1, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) @(negedge clk);
    // R1: reset values
    check("R1 todoCount", todoCount, 0);
    check("R1 sckEn", sckEn, 0);
    check("R1 pushValid", pushValid, 0);
    check("R1 rxIrq", rxIrq, 0);
    rstN = 1'b1;

    // R3: zero count is ignored, stray bytes with clock off ignored (R4)
    step(1'b1, 0, 1'b1, 1'b0);
    step(1'b0, 0, 1'b1, 1'b0);
    step(1'b0, 0, 1'b0, 1'b0);
    check("R3 zero write ignored", todoCount, 0);

    runReq(8, 3, 0, 4);    // R5 full words, R3 write while busy
    runReq(6, 2, 0, 0);    // R6 two trailing bytes
    runReq(1, 1, 0, 0);    // R6 single byte
    runReq(3, 4, 0, 2);    // R6 three bytes
    runReq(7, 1, 0, 0);    // back-to-back bytes
    runReq(13, 1, 1, 5);   // R7 FIFO full stretches
    runReq(20, 1, 2, 0);   // R7 heavy back-pressure
    runReq(9, 3, 2, 0);

    check("R5 full words observed", fullSeen > 0, 1);
    check("R6 partial words observed", partialSeen > 0, 1);
    check("R7 held word observed", holdSeen > 0, 1);
    check("R4 idle at end", sckEn, 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule